// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed store in which every word carries one tag bit that marks it as holding a value ("full") or as waiting for one ("empty"). Threads send it requests, each with a thread number. Plain reads and plain writes behave like an ordinary memory. Two synchronizing operations also use the tag. A *take* waits until the word is full, returns it and marks it empty. A *put* waits until the word is empty, stores the value and marks it full. Producer/consumer hand-off and locking are both built from these two: take acts as lock and consume, and put acts as unlock and produce.

A synchronizing request that cannot complete at once is held in a small ordered wait list. The list holds the address, the thread number, the operation and any write data. Each cycle the block checks the held requests against the current tags. The oldest request whose condition now holds is completed, ahead of any new request. A completed request produces a one-cycle response carrying the thread number and the data. The block serves at most one operation per cycle.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is full and every word reads as zero. No response is pending, and `req_ready` is high while the wait list is empty.
- R2: A plain read (`req_op` = 0) ignores the tag and never waits. In the cycle after it is accepted, `rsp_valid` is high, with the word in `rsp_data` and the request's thread number in `rsp_tid`. The tag is left unchanged.
- R3: A plain write (`req_op` = 1) ignores the tag and never waits. It stores `req_wdata`, leaves the tag unchanged, and responds one cycle later with the written value.
- R4: A take (`req_op` = 2) to a full word responds one cycle later with the word's value, and the word becomes empty.
- R5: A take to an empty word is accepted and held. It produces no response until the word becomes full.
- R6: A put (`req_op` = 3) to an empty word stores `req_wdata` and marks the word full. It responds one cycle later with the written value.
- R7: A put to a full word is accepted and held until the word becomes empty.
- R8: In any cycle where a held request's condition is met, the oldest such request is completed and `req_ready` is low. Its response follows one cycle later with its own thread number.
- R9: One fill of a word releases only one held take on that word. The remaining takes stay held until the next fill.
- R10: The wait list holds `PEND_DEPTH` requests. While it is full, a request that would have to wait is refused (`req_ready` low). A request that would complete at once is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_op | input | 2 | 0 plain read, 1 plain write, 2 take, 3 put |
| req_addr | input | ADDR_W (4) | Word address |
| req_tid | input | TID_W (3) | Requesting thread number |
| req_wdata | input | DATA_W (16) | Write data for plain write and put |
| req_ready | output | 1 | Request is accepted this cycle when also valid |
| rsp_valid | output | 1 | A request completed in the previous cycle |
| rsp_tid | output | TID_W (3) | Thread number of the completed request |
| rsp_data | output | DATA_W (16) | Read value, or the written value for writes |

## Verification
The hardest states to reach are a word that has several takes held against it, and a full wait list that is facing both a blocking and a non-blocking request. The stimulus reaches the first by emptying a word with one take, queuing further takes from different threads, and then filling the word with successive puts. After each put it checks that only the oldest held take completes. It reaches the second by holding as many takes as the list has slots. It then offers one more take, which must be refused, and then a put, which must be accepted and begin draining the list. A long mixed run on four addresses follows, checked against a queue-based model of the same rules.

// File: rtl/fe_sync_pkg.sv
package fe_sync_pkg;

    parameter int ADDR_W = 4;
    parameter int DATA_W = 16;
    parameter int TID_W  = 3;
    localparam int WORDS = 1 << ADDR_W;

    typedef enum logic [1:0] {
        OP_PLAIN_RD = 2'd0,
        OP_PLAIN_WR = 2'd1,
        OP_TAKE     = 2'd2,
        OP_PUT      = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [TID_W-1:0]  tid;
        logic [DATA_W-1:0] data;
    } waiter_t;

    // True when an operation may complete against a word with this tag.
    function automatic logic may_go(op_e op, logic tag_full);
        case (op)
            OP_TAKE: may_go = tag_full;
            OP_PUT:  may_go = !tag_full;
            default: may_go = 1'b1;
        endcase
    endfunction

    function automatic logic is_sync(op_e op);
        is_sync = (op == OP_TAKE) || (op == OP_PUT);
    endfunction

    function automatic logic writes_word(op_e op);
        writes_word = (op == OP_PLAIN_WR) || (op == OP_PUT);
    endfunction

endpackage

// File: rtl/fe_word_bank.sv
module fe_word_bank
    import fe_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_en,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic              tag_val,
    output logic [WORDS-1:0]  tags
);

    logic [DATA_W-1:0] word_q [WORDS];
    logic [WORDS-1:0]  tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
            tag_q <= '1;
        end else begin
            if (wr_en)  word_q[wr_addr] <= wr_data;
            if (tag_en) tag_q[tag_addr] <= tag_val;
        end
    end

    assign rd_data = word_q[rd_addr];
    assign tags    = tag_q;

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tag_en |=> $stable(tag_q)); // R2
    AST_WORD_STORED: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> word_q[$past(wr_addr)] == $past(wr_data)); // R3

endmodule

// File: rtl/fe_wait_list.sv
module fe_wait_list
    import fe_sync_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WORDS-1:0] tags,
    input  logic             push,
    input  waiter_t          push_w,
    input  logic             pop,
    output logic             hit,
    output waiter_t          hit_w,
    output logic             full
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    waiter_t         slot_q [DEPTH];
    logic [CW-1:0]   cnt_q;
    logic [DEPTH-1:0] elig;
    logic [IW-1:0]   hit_idx;

    // A slot is eligible when it is occupied and its word's tag now permits it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign elig[g] = (g < int'(cnt_q)) && may_go(slot_q[g].op, tags[slot_q[g].addr]);
    end

    // Slot 0 is the oldest; the first eligible slot wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && elig[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign hit_w = slot_q[hit_idx];
    assign full  = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(hit_idx)) slot_q[i] <= slot_q[i+1];
            end
            cnt_q <= cnt_q - 1'b1;
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(cnt_q)) slot_q[i] <= push_w;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_PUSH_WITH_POP: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R8
    AST_POP_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        pop |-> hit); // R8
    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH); // R10

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
    import fe_sync_pkg::*;
#(
    parameter int PEND_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [TID_W-1:0]  rsp_tid,
    output logic [DATA_W-1:0] rsp_data
);

    waiter_t          in_w, hit_w, cur_w;
    logic             hit, full;
    logic             in_parks, fire, act, push;
    logic [WORDS-1:0] tags;
    logic [DATA_W-1:0] rd_data;

    assign in_w.op   = op_e'(req_op);
    assign in_w.addr = req_addr;
    assign in_w.tid  = req_tid;
    assign in_w.data = req_wdata;

    // Held requests whose condition is met go before new ones.
    assign in_parks  = is_sync(in_w.op) && !may_go(in_w.op, tags[req_addr]);
    assign req_ready = !hit && (!full || !in_parks);
    assign fire      = req_valid && req_ready;
    assign push      = fire && in_parks;
    assign act       = hit || (fire && !in_parks);
    assign cur_w     = hit ? hit_w : in_w;

    fe_wait_list #(.DEPTH(PEND_DEPTH)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .tags   (tags),
        .push   (push),
        .push_w (in_w),
        .pop    (hit),
        .hit    (hit),
        .hit_w  (hit_w),
        .full   (full)
    );

    fe_word_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (cur_w.addr),
        .rd_data  (rd_data),
        .wr_en    (act && writes_word(cur_w.op)),
        .wr_addr  (cur_w.addr),
        .wr_data  (cur_w.data),
        .tag_en   (act && is_sync(cur_w.op)),
        .tag_addr (cur_w.addr),
        .tag_val  (cur_w.op == OP_PUT),
        .tags     (tags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= act;
            if (act) begin
                rsp_tid  <= cur_w.tid;
                rsp_data <= writes_word(cur_w.op) ? cur_w.data : rd_data;
            end
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        act |=> rsp_valid); // R2
    AST_PARK_SILENT: assert property (@(posedge clk) disable iff (rst)
        push |=> !rsp_valid); // R5
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (act && cur_w.op == OP_TAKE) |=> !tags[$past(cur_w.addr)]); // R4
    AST_PUT_FILLS: assert property (@(posedge clk) disable iff (rst)
        (act && cur_w.op == OP_PUT) |=> tags[$past(cur_w.addr)]); // R6
    AST_ONE_TAKE_PER_FILL: assert property (@(posedge clk) disable iff (rst)
        (act && cur_w.op == OP_TAKE) |=>
        !(act && cur_w.op == OP_TAKE && cur_w.addr == $past(cur_w.addr))); // R9
    AST_RETRY_BLOCKS_IN: assert property (@(posedge clk) disable iff (rst)
        hit |-> !req_ready); // R8

endmodule

// File: tb/fe_sync_mem_test.sv
module fe_sync_mem_test;

    localparam int PEND = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [3:0]  req_addr = '0;
    logic [2:0]  req_tid = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [2:0]  rsp_tid;
    logic [15:0] rsp_data;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int op;
        int addr;
        int tid;
        int data;
    } mreq_t;

    int    mmem [16];
    bit    mtag [16];
    mreq_t mq [$];

    always #4 clk = ~clk;

    fe_sync_mem #(.PEND_DEPTH(PEND)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_tid(req_tid), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_tid(rsp_tid),
        .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit m_go(input int op, input int addr);
        if (op == 2) return mtag[addr];
        if (op == 3) return !mtag[addr];
        return 1'b1;
    endfunction

    // One cycle: drive, check ready, advance the model, check the response.
    task automatic step(input bit v, input int op, input int a, input int t,
                        input int d, input string rq);
        int    idx;
        bit    exp_ready, exp_rv, parks;
        int    exp_tid, exp_data;
        mreq_t cur;
        @(negedge clk);
        req_valid = v;
        req_op    = op[1:0];
        req_addr  = a[3:0];
        req_tid   = t[2:0];
        req_wdata = d[15:0];
        #1;
        idx = -1;
        foreach (mq[i]) if (idx < 0 && m_go(mq[i].op, mq[i].addr)) idx = i;
        parks     = (op >= 2) && !m_go(op, a);
        exp_ready = (idx < 0) && (mq.size() < PEND || !parks);
        chk(req_ready == exp_ready, rq, "req_ready", req_ready, exp_ready);
        exp_rv = 1'b0; exp_tid = 0; exp_data = 0;
        if (idx >= 0) begin
            cur = mq[idx];
            mq.delete(idx);
            exp_rv = 1'b1;
        end else if (v && exp_ready) begin
            cur.op = op; cur.addr = a; cur.tid = t; cur.data = d;
            if (parks) mq.push_back(cur);
            else exp_rv = 1'b1;
        end
        if (exp_rv) begin
            exp_tid = cur.tid;
            if (cur.op == 1 || cur.op == 3) begin
                mmem[cur.addr] = cur.data;
                exp_data = cur.data;
            end else begin
                exp_data = mmem[cur.addr];
            end
            if (cur.op == 2) mtag[cur.addr] = 1'b0;
            if (cur.op == 3) mtag[cur.addr] = 1'b1;
        end
        @(posedge clk);
        #2;
        chk(rsp_valid == exp_rv, rq, "rsp_valid", rsp_valid, exp_rv);
        if (exp_rv) begin
            chk(int'(rsp_tid) == exp_tid, rq, "rsp_tid", rsp_tid, exp_tid);
            chk(int'(rsp_data) == exp_data, rq, "rsp_data", rsp_data, exp_data);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mmem[i] = 0; mtag[i] = 1'b1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        step(0, 0, 0, 0, 0, "R1 idle");
        step(1, 0, 5, 1, 0, "R1 reads zero");
        step(1, 2, 12, 2, 0, "R1 tag full after reset");

        // R2 / R3: plain access
        step(1, 1, 3, 3, 16'hA5A5, "R3 plain write");
        step(1, 0, 3, 4, 0, "R2 plain read");

        // R4: take of a full word, then plain ops still pass the empty tag
        step(1, 2, 3, 5, 0, "R4 take full word");
        step(1, 0, 3, 6, 0, "R2 read ignores empty tag");
        step(1, 1, 3, 6, 16'h0BB0, "R3 write keeps tag empty");

        // R5 / R9: two takes wait on word 3
        step(1, 2, 3, 1, 0, "R5 take parks");
        step(1, 2, 3, 2, 0, "R5 second take parks");
        step(0, 0, 0, 0, 0, "R5 no response while empty");
        step(1, 3, 3, 4, 16'h1111, "R6 put to empty word");
        step(1, 0, 9, 7, 0, "R8 retry first (oldest take)");
        step(0, 0, 0, 0, 0, "R9 second take still held");
        step(1, 3, 3, 4, 16'h2222, "R9 next fill");
        step(0, 0, 0, 0, 0, "R9 second take released");

        // R7: put to a full word waits for a take
        step(1, 3, 7, 3, 16'h7777, "R7 put to full parks");
        step(0, 0, 0, 0, 0, "R7 held");
        step(1, 2, 7, 5, 0, "R7 take empties word");
        step(0, 0, 0, 0, 0, "R8 held put completes");
        step(1, 0, 7, 6, 0, "R7 put data landed");

        // R10: fill the wait list
        step(1, 2, 9, 0, 0, "R10 empty word 9");
        for (int k = 0; k < PEND; k++) step(1, 2, 9, k + 1, 0, "R10 park take");
        step(1, 2, 9, 6, 0, "R10 blocking request refused");
        step(1, 0, 9, 6, 0, "R10 plain read accepted when full");
        for (int k = 0; k < PEND; k++) begin
            step(1, 3, 9, 7, 16'h9000 + k, "R10 put drains list");
            step(0, 0, 0, 0, 0, "R9 one take per fill");
        end

        // R8: mixed traffic on a few words
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 4),
                 int'($urandom % 8), int'($urandom % 65536), "R8 mixed");
        end
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 0, "R8 settle");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule